// File: doc/BRIEF.md
# Function Event Interrupt Controller

This block drives one active-low interrupt pin from a set of internal interrupt sources. Each source has its own enable from the local configuration, and the enabled sources are ORed into one request. A mode input picks one of two behaviours. In pass-through mode the request reaches the pin directly, one register stage later. In latched mode the request sets an event latch. The pin asserts only while that latch and a mask bit are both set.

Software uses a small register window with four addresses. The event register is cleared by writing 1 to it. The mask register can be read and written. The present-state register is read-only and shows the live request. The force register is write-only; writing 1 to it sets the event latch as a debug interrupt. Only one bit position, the INTR bit (bit 15 by default), carries meaning in each register. A write of 1 to the event bit, or a write of 0 to the mask bit, lets the pin go high on the next cycle.

Top module: `fevt_irq_ctrl`

## Requirements
- R1: While reset is held and after it is released, `irq_n` is 1 and the event latch, the mask and `rdata` are all 0.
- R2: With `enh_mode`=0, `irq_n` in cycle t+1 equals the inverse of the gated request in cycle t. The event latch and the mask have no effect on the pin.
- R3: With `enh_mode`=1, `irq_n` in cycle t+1 is 0 exactly when the event latch and the mask, as updated at the end of cycle t, are both 1.
- R4: The event latch sets at the end of any cycle in which the gated request is 1. It stays set after the request falls until it is cleared.
- R5: A write to address 0 with `wdata[15]`=1 clears the event latch. A write to address 0 with `wdata[15]`=0 changes nothing.
- R6: If a clear of the event latch and a gated request fall in the same cycle, the latch stays 1.
- R7: A write to address 1 stores `wdata[15]` as the mask. In latched mode, writing 0 raises `irq_n` on the next cycle.
- R8: A read of address 2 returns, in bit 15, the non-latched gated request of the cycle in which the address was presented.
- R9: A write to address 3 with `wdata[15]`=1 sets the event latch.
- R10: A source whose bit in `src_en` is 0 affects neither the pin, the event latch nor the present-state view.
- R11: `rdata` in cycle t+1 holds the register selected by `addr` in cycle t, taken before that cycle's write. The register value sits in bit 15, every other bit is 0, and address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Raw interrupt request per source |
| src_en | input | NUM_SRC | Per-source enable from local configuration |
| enh_mode | input | 1 | 1 selects latched mode, 0 pass-through |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 event, 1 mask, 2 present, 3 force |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
Both the pin and the read data come from one register stage. A stimulus applied in cycle t therefore shows up after the next rising edge, and every result is due exactly one cycle later. The driver applies inputs on the falling edge and, in the same step, works out the expected pin level and read word from its own model. It pushes both into a queue. The monitor pops one entry just after each rising edge and compares it, so each expectation meets the cycle it was computed for. Read data reflects state from before that cycle's write, so a read and a write to the same address can share a cycle.

// File: rtl/fevt_pkg.sv
package fevt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_EVENT   = 2'd0,
    REG_MASK    = 2'd1,
    REG_PRESENT = 2'd2,
    REG_FORCE   = 2'd3
  } fevt_reg_e;
endpackage

// File: rtl/fevt_src_gate.sv
module fevt_src_gate #(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  output logic               req
);
  logic [NUM_SRC-1:0] gated;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign gated[i] = src_req[i] & src_en[i];
  end

  assign req = |gated;
endmodule

// File: rtl/fevt_event_latch.sv
module fevt_event_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic evt_next,
  output logic evt_q
);
  // A set in the same cycle as a clear wins.
  assign evt_next = (evt_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= evt_next;
  end

  assert_set_R4: assert property (@(posedge clk) disable iff (rst)
    set_i |=> evt_q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !clr_i) |=> evt_q);
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !evt_q);
endmodule

// File: rtl/fevt_regs.sv
module fevt_regs
  import fevt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int INTR_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_q,
  input  logic              req,
  output logic              clr,
  output logic              fset,
  output logic              mask_next,
  output logic              mask_q,
  output logic [DATA_W-1:0] rdata
);
  logic wr_evt, wr_mask, wr_force;
  logic rd_bit;

  assign wr_evt   = wr_en && (addr == REG_EVENT);
  assign wr_mask  = wr_en && (addr == REG_MASK);
  assign wr_force = wr_en && (addr == REG_FORCE);

  assign clr       = wr_evt & wdata[INTR_BIT];
  assign fset      = wr_force & wdata[INTR_BIT];
  assign mask_next = wr_mask ? wdata[INTR_BIT] : mask_q;

  always_comb begin
    case (fevt_reg_e'(addr))
      REG_EVENT:   rd_bit = evt_q;
      REG_MASK:    rd_bit = mask_q;
      REG_PRESENT: rd_bit = req;
      default:     rd_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      rdata  <= '0;
    end else begin
      mask_q <= mask_next;
      rdata  <= DATA_W'(rd_bit) << INTR_BIT;
    end
  end

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_q == $past(wdata[INTR_BIT])));
  assert_force_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_FORCE) |=> (rdata == '0));
endmodule

// File: rtl/fevt_irq_ctrl.sv
module fevt_irq_ctrl
  import fevt_pkg::*;
#(
  parameter int NUM_SRC  = 3,
  parameter int DATA_W   = 32,
  parameter int INTR_BIT = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               enh_mode,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_n
);
  logic req, clr, fset, evt_next, evt_q, mask_next, mask_q;

  fevt_src_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .src_req (src_req),
    .src_en  (src_en),
    .req     (req)
  );

  fevt_event_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .set_i    (req | fset),
    .clr_i    (clr),
    .evt_next (evt_next),
    .evt_q    (evt_q)
  );

  fevt_regs #(.DATA_W(DATA_W), .INTR_BIT(INTR_BIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .evt_q     (evt_q),
    .req       (req),
    .clr       (clr),
    .fset      (fset),
    .mask_next (mask_next),
    .mask_q    (mask_q),
    .rdata     (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)           irq_n <= 1'b1;
    else if (enh_mode) irq_n <= ~(evt_next & mask_next);
    else               irq_n <= ~req;
  end

  assert_legacy_pass_R2: assert property (@(posedge clk) disable iff (rst)
    !enh_mode |=> (irq_n == !$past(req)));
  assert_enh_gate_R3: assert property (@(posedge clk) disable iff (rst)
    enh_mode |=> (irq_n == !(evt_q && mask_q)));
  assert_mask_off_R7: assert property (@(posedge clk) disable iff (rst)
    (enh_mode && wr_en && addr == REG_MASK && !wdata[INTR_BIT]) |=> irq_n);
endmodule

// File: tb/tb_fevt_irq_ctrl.sv
module tb_fevt_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int DW = 32;
  localparam int IB = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] src_req = '0, src_en = '0;
  logic enh_mode = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_n;

  typedef struct {
    logic          irq;
    logic [DW-1:0] rd;
    string         tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  logic m_evt = 1'b0, m_mask = 1'b0;
  bit done = 0;

  fevt_irq_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .INTR_BIT(IB)) dut (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
    .enh_mode(enh_mode), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic cyc(string tag, logic [NS-1:0] s, logic [NS-1:0] e, logic enh,
                     logic w, logic [1:0] a, logic wb);
    logic req, clr, fs, evt_n, mask_n, rb;
    exp_t it;
    @(negedge clk);
    src_req = s; src_en = e; enh_mode = enh; wr_en = w; addr = a;
    wdata = {DW{1'b1}};
    wdata[IB] = wb;
    req    = |(s & e);
    clr    = w && a == 2'd0 && wb;
    fs     = w && a == 2'd3 && wb;
    evt_n  = (m_evt & ~clr) | req | fs;
    mask_n = (w && a == 2'd1) ? wb : m_mask;
    case (a)
      2'd0: rb = m_evt;
      2'd1: rb = m_mask;
      2'd2: rb = req;
      default: rb = 1'b0;
    endcase
    it.irq = enh ? !(evt_n & mask_n) : !req;
    it.rd  = DW'(rb) << IB;
    it.tag = tag;
    q.push_back(it);
    m_evt  = evt_n;
    m_mask = mask_n;
  endtask

  // Monitor: results are due just after the rising edge that follows the drive.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check({it.tag, " irq_n"}, DW'(irq_n), DW'(it.irq));
      check({it.tag, " rdata"}, rdata, it.rd);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset irq_n", DW'(irq_n), DW'(1'b1));
    check("R1 reset rdata", rdata, '0);
    rst = 1'b0;
    cyc("R1 event reads 0",   3'b000, 3'b111, 1'b1, 1'b0, 2'd0, 1'b0);
    cyc("R1 mask reads 0",    3'b000, 3'b111, 1'b1, 1'b0, 2'd1, 1'b0);
    // pass-through
    cyc("R2 legacy req on",   3'b001, 3'b111, 1'b0, 1'b0, 2'd2, 1'b0);
    cyc("R2 legacy req off",  3'b000, 3'b111, 1'b0, 1'b0, 2'd0, 1'b0);
    cyc("R2 legacy clr",      3'b000, 3'b111, 1'b0, 1'b1, 2'd0, 1'b1);
    cyc("R2 legacy mask on",  3'b000, 3'b111, 1'b0, 1'b1, 2'd1, 1'b1);
    cyc("R2 legacy src2",     3'b100, 3'b111, 1'b0, 1'b0, 2'd1, 1'b0);
    cyc("R2 legacy ignore",   3'b000, 3'b111, 1'b0, 1'b0, 2'd0, 1'b0);
    cyc("R5 clr",             3'b000, 3'b111, 1'b1, 1'b1, 2'd0, 1'b1);
    cyc("R7 mask off",        3'b000, 3'b111, 1'b1, 1'b1, 2'd1, 1'b0);
    // disabled source
    cyc("R10 masked src",     3'b001, 3'b110, 1'b1, 1'b0, 2'd2, 1'b0);
    cyc("R10 evt untouched",  3'b000, 3'b110, 1'b1, 1'b0, 2'd0, 1'b0);
    // latched mode
    cyc("R4 set, mask 0",     3'b010, 3'b111, 1'b1, 1'b0, 2'd2, 1'b0);
    cyc("R4 held read",       3'b000, 3'b111, 1'b1, 1'b0, 2'd0, 1'b0);
    cyc("R3 mask on",         3'b000, 3'b111, 1'b1, 1'b1, 2'd1, 1'b1);
    cyc("R4 hold asserted",   3'b000, 3'b111, 1'b1, 1'b0, 2'd1, 1'b0);
    cyc("R5 write 0 no-op",   3'b000, 3'b111, 1'b1, 1'b1, 2'd0, 1'b0);
    cyc("R5 still set",       3'b000, 3'b111, 1'b1, 1'b0, 2'd0, 1'b0);
    cyc("R5 w1c",             3'b000, 3'b111, 1'b1, 1'b1, 2'd0, 1'b1);
    cyc("R5 cleared read",    3'b000, 3'b111, 1'b1, 1'b0, 2'd0, 1'b0);
    cyc("R8 live high",       3'b100, 3'b111, 1'b1, 1'b0, 2'd2, 1'b0);
    cyc("R6 set beats clr",   3'b100, 3'b111, 1'b1, 1'b1, 2'd0, 1'b1);
    cyc("R8 live low",        3'b000, 3'b111, 1'b1, 1'b0, 2'd2, 1'b0);
    cyc("R6 latch kept",      3'b000, 3'b111, 1'b1, 1'b0, 2'd0, 1'b0);
    cyc("R7 mask clr",        3'b000, 3'b111, 1'b1, 1'b1, 2'd1, 1'b0);
    cyc("R3 mask 0 pin high", 3'b000, 3'b111, 1'b1, 1'b0, 2'd0, 1'b0);
    cyc("R5 clear again",     3'b000, 3'b111, 1'b1, 1'b1, 2'd0, 1'b1);
    cyc("R3 mask on empty",   3'b000, 3'b111, 1'b1, 1'b1, 2'd1, 1'b1);
    cyc("R9 force 0 no-op",   3'b000, 3'b111, 1'b1, 1'b1, 2'd3, 1'b0);
    cyc("R9 force",           3'b000, 3'b111, 1'b1, 1'b1, 2'd3, 1'b1);
    cyc("R11 force reads 0",  3'b000, 3'b111, 1'b1, 1'b0, 2'd3, 1'b0);
    cyc("R9 event set",       3'b000, 3'b111, 1'b1, 1'b0, 2'd0, 1'b0);
    cyc("R2 back to legacy",  3'b000, 3'b111, 1'b0, 1'b0, 2'd0, 1'b0);
    cyc("R11 mask read",      3'b000, 3'b111, 1'b0, 1'b0, 2'd1, 1'b0);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule